// File: doc/BRIEF.md
# Recursive Sine Tone Oscillator

This block produces a sampled sine tone without any lookup table. It holds two past samples and a coefficient, and on every sample-enable pulse forms the next sample as the coefficient times the newest sample minus the older one. All three quantities are 16-bit signed values. The coefficient is fixed point with 14 fraction bits. A coefficient of 2·cos(2π·fo/fs) gives a tone at frequency fo for a sample rate fs. For example, a 770 Hz tone sampled at 8 kHz needs a coefficient near 26957.

Software or a sequencer loads the coefficient and a starting value with one load strobe. The starting value fixes the amplitude of the tone; a zero start gives silence. After loading, a periodic enable, such as an 8 kHz tick, steps the oscillator. The current sample is available as a signed value. It is also available as a 12-bit offset-binary code that can go straight to a DAC, where a signed zero maps to mid-scale.

Top module: `sine_resonator`

## Requirements
- R1: After reset, the signed sample output is 0, the DAC code is 2048, and the stored coefficient is 0.
- R2: A cycle with `load` high stores `coef_in` as the coefficient, makes `init_in` the current sample, and clears the older sample to 0. The outputs show the new state one clock later.
- R3: When `load` and `step` are high in the same cycle, the load takes effect and no step is taken.
- R4: In a cycle with both `load` and `step` low, the coefficient and both samples keep their values.
- R5: In a cycle with `step` high and `load` low, the new sample is computed as follows. First form the full 32-bit signed product of the coefficient (signed, bit 15 the sign, 14 fraction bits) and the current sample. Add 8192 to the product, shift it arithmetically right by 14, and subtract the older sample. The old current sample then becomes the older sample.
- R6: A result from R5 above 32767 is stored as 32767, and one below −32768 is stored as −32768.
- R7: `dac_code` equals (sample + 32768) shifted right by 4, i.e. offset binary with mid-scale 2048.
- R8: With a 770 Hz / 8 kHz coefficient and a nonzero start, the sample sequence follows R5 over many hundred steps without drift from the reference computation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| load | input | 1 | Load coefficient and starting sample |
| coef_in | input | 16 | Coefficient, signed, 14 fraction bits |
| init_in | input | 16 | Starting sample, signed |
| step | input | 1 | Sample enable; advances the recurrence |
| sample_out | output | 16 | Current sample, signed |
| dac_code | output | 12 | Current sample as unsigned offset-binary code |

## Verification
The hardest situations to reach are the saturation limits. A stable tone never comes near full scale, so normal stimulus never exercises the clamp. The bench reaches both limits on purpose. It loads the extreme coefficients (+32767 and −32768) with large starting values of either sign, which drives the very first step past each bound. It also loads over a running tone and raises load together with step, to confirm that the older sample is truly cleared and that a step in the same cycle is dropped.

// File: rtl/sine_resonator.sv
module sine_resonator #(
  parameter int W    = 16,
  parameter int FRAC = 14,
  parameter int OW   = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] coef_in,
  input  logic [W-1:0] init_in,
  input  logic         step,
  output logic [W-1:0] sample_out,
  output logic [OW-1:0] dac_code
);
  localparam int PW = 2 * W;
  localparam logic signed [PW-1:0] HALF = PW'(1) <<< (FRAC - 1);
  localparam logic signed [PW-1:0] MAXV = (PW'(1) <<< (W - 1)) - PW'(1);
  localparam logic signed [PW-1:0] MINV = -(PW'(1) <<< (W - 1));

  logic signed [W-1:0]  coef_q, cur_q, old_q;
  logic signed [PW-1:0] prod, scaled, diff;
  logic signed [W-1:0]  nxt;

  assign prod   = PW'(coef_q) * PW'(cur_q);
  assign scaled = (prod + HALF) >>> FRAC;
  assign diff   = scaled - PW'(old_q);

  always_comb begin
    if (diff > MAXV)      nxt = MAXV[W-1:0];
    else if (diff < MINV) nxt = MINV[W-1:0];
    else                  nxt = diff[W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      coef_q <= '0;
      cur_q  <= '0;
      old_q  <= '0;
    end else if (load) begin
      coef_q <= coef_in;
      cur_q  <= init_in;
      old_q  <= '0;
    end else if (step) begin
      cur_q  <= nxt;
      old_q  <= cur_q;
    end
  end

  assign sample_out = cur_q;
  assign dac_code   = {~cur_q[W-1], cur_q[W-2 -: OW-1]};

  assert_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (cur_q == $past(init_in)) && (old_q == '0) && (coef_q == $past(coef_in)));

  assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !step) |=> $stable(cur_q) && $stable(old_q) && $stable(coef_q));

  assert_shift_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load) |=> old_q == $past(cur_q));

  assert_zero_coef_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load && coef_q == '0 && old_q != MINV[W-1:0]) |=> cur_q == -$past(old_q));

  assert_clamp_hi_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load && cur_q > 0 && coef_q == MAXV[W-1:0] && old_q <= 0 && cur_q > 20000)
      |=> cur_q == MAXV[W-1:0]);
endmodule

// File: tb/sine_resonator_test.sv
module sine_resonator_test;
  logic clk = 0;
  logic rst_n = 0;
  logic load = 0, step = 0;
  logic [15:0] coef_in = '0, init_in = '0;
  logic [15:0] sample_out;
  logic [11:0] dac_code;
  int errors = 0, checks = 0;
  int my1 = 0, my2 = 0, mk = 0;
  bit done = 0;

  always #2 clk = ~clk;

  sine_resonator uut (.clk(clk), .rst_n(rst_n), .load(load), .coef_in(coef_in),
    .init_in(init_in), .step(step), .sample_out(sample_out), .dac_code(dac_code));

  function automatic int s16(input logic [15:0] v);
    return int'(signed'(v));
  endfunction

  task automatic check(input string tag);
    int exp_dac;
    exp_dac = (my1 + 32768) >>> 4;
    checks++;
    if (s16(sample_out) != my1) begin
      errors++;
      $display("FAIL %s sample actual=%0d expected=%0d", tag, s16(sample_out), my1);
    end
    checks++;
    if (int'(dac_code) != exp_dac) begin
      errors++;
      $display("FAIL R7 (%s) dac actual=%0d expected=%0d", tag, dac_code, exp_dac);
    end
  endtask

  // called at negedge: check current outputs, drive inputs, advance the model
  task automatic cyc(input bit ld, input int k, input int init, input bit en, input string tag);
    int p, n;
    check(tag);
    load = ld; step = en;
    coef_in = 16'(k); init_in = 16'(init);
    if (ld) begin
      mk = k; my1 = init; my2 = 0;
    end else if (en) begin
      p = mk * my1;
      n = ((p + 8192) >>> 14) - my2;
      if (n > 32767) n = 32767;
      if (n < -32768) n = -32768;
      my2 = my1; my1 = n;
    end
    @(negedge clk);
  endtask

  initial begin
    @(negedge clk); @(negedge clk);
    rst_n = 1;
    // R1: reset state
    cyc(0, 0, 0, 1, "R1");   // step with k=0 on zero state keeps zero
    cyc(0, 0, 0, 0, "R1");
    // R2: load, then R5 steps
    cyc(1, 16384, 1000, 0, "R2");
    cyc(0, 0, 0, 0, "R2");
    for (int i = 0; i < 8; i++) cyc(0, 0, 0, 1, "R5");
    // R4: hold with garbage on data inputs
    cyc(0, 12345, -777, 0, "R4");
    cyc(0, 999, 4321, 0, "R4");
    cyc(0, 0, 0, 1, "R5");
    // R3: load and step together
    cyc(1, -20000, -3000, 1, "R3");
    cyc(0, 0, 0, 1, "R3");
    cyc(0, 0, 0, 1, "R5");
    // R6: saturation high and low
    cyc(1, 32767, 30000, 0, "R6");
    cyc(0, 0, 0, 1, "R6");
    cyc(0, 0, 0, 1, "R6");
    cyc(1, -32768, 30000, 0, "R6");
    cyc(0, 0, 0, 1, "R6");
    cyc(0, 0, 0, 1, "R6");
    cyc(1, -32768, -32768, 1, "R6");
    cyc(0, 0, 0, 1, "R6");
    // R8: 770 Hz tone at 8 kHz, with idle gaps between samples
    cyc(1, 26957, 6000, 0, "R8");
    for (int i = 0; i < 600; i++) begin
      cyc(0, 0, 0, 1, "R8");
      if (i % 7 == 0) cyc(0, 0, 0, 0, "R4");
    end
    // R2: reload over a running tone clears the older sample
    cyc(1, 26957, -9000, 0, "R2");
    cyc(0, 0, 0, 1, "R2");
    cyc(0, 0, 0, 1, "R2");
    check("R8");
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule